// File: doc/BRIEF.md
# Fixed-Point Requantizer with Selectable Rounding

This unit moves a fixed-point sample from one Q format to another. The caller fixes both formats at elaboration time through four parameters: total width and fraction-bit count for the input, and the same pair for the output. The bit vector on its own never tells the unit where the binary point sits. The integer-bit count of each side, sign bit included, is the width minus the fraction count. A further parameter chooses between two's-complement and unsigned interpretation.

When the output keeps fewer fraction bits than the input, a two-bit mode input chooses how the discarded bits are folded into the result. The choices are truncation toward minus infinity, rounding toward plus infinity, rounding half away upward, and rounding half to even. The last one removes the steady bias that truncation leaves in accumulated signal paths. When the output keeps more fraction bits, zeros are appended and the mode has no effect.

Integer bits are sign- or zero-extended when the output is wider. If the rounded value does not fit the output range, the result clamps to the nearest extreme code and an overflow flag is raised. A parameter selects between a purely combinational path and a one-cycle registered path with a valid strobe. A typical use is after a multiplier or adder whose full-precision result has grown, for example a Q2.30 product of two Q1.15 operands.

Top module: `fxp_requant`

## Requirements
- R1: In the registered variant, while `rst` is high at a rising clock edge, `out_valid`, `out_data` and `out_ovf` all become 0.
- R2: In the registered variant, `out_valid` equals `in_valid` of the previous cycle, and each accepted input yields exactly one result one cycle later, in order.
- R3: If the rounded value is above the largest output code, `out_data` is that largest code (signed: 0 followed by all ones). If it is below the smallest code, `out_data` is that smallest code (signed: 1 followed by all zeros). In both cases `out_ovf` is 1; otherwise `out_ovf` is 0.
- R4: Mode 2'b00 (floor) drops the discarded fraction bits with no adjustment. An input whose discarded bits are all zero gives the same exact result in every mode.
- R5: Mode 2'b01 (ceiling) adds one output LSB whenever any discarded bit is 1.
- R6: Mode 2'b10 (half-up) adds one output LSB whenever the most significant discarded bit is 1.
- R7: Mode 2'b11 (half-even) acts as half-up, except on an exact tie: the top discarded bit is 1 and all lower discarded bits are 0. On a tie it adds one only when the kept LSB is 1.
- R8: In the registered variant, a cycle with `in_valid` low leaves `out_data` and `out_ovf` unchanged.
- R9: When the output has more fraction bits than the input, the result is the input with zeros appended on the right and the integer part sign-extended. The mode has no effect and `out_ovf` stays 0 if the value fits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the registered variant |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input sample strobe |
| in_data | input | IN_W | Input sample, IN_FRAC fraction bits |
| mode | input | 2 | Rounding mode: 00 floor, 01 ceiling, 10 half-up, 11 half-even |
| out_valid | output | 1 | Result strobe |
| out_data | output | OUT_W | Requantized sample, OUT_FRAC fraction bits |
| out_ovf | output | 1 | Result was clamped to the output range |

## Verification
A fault in the guard or sticky extraction appears as a one-LSB error, but only for the modes and fraction patterns that consult the faulty term. For that reason, exact ties with both odd and even kept LSBs, and negative ties, are applied in all four modes. A fault in the range limits appears as an unclamped wrap or a missing flag, and it shows only on samples at the range edges. This includes a sample that only overflows once rounding carries it past the top code. A fault in the output register shows at the next strobe, either as a shifted result sequence or as a value that changes during idle cycles.

// File: rtl/fxp_requant_pkg.sv
package fxp_requant_pkg;

   typedef enum logic [1:0] {
      RQ_FLOOR     = 2'b00,
      RQ_CEIL      = 2'b01,
      RQ_HALF_UP   = 2'b10,
      RQ_HALF_EVEN = 2'b11
   } rq_mode_e;

   function automatic int rq_max(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/fxp_align_round.sv
// Aligns the input binary point to the output one and applies the rounding
// increment. Result is a wide signed value, not yet range-limited.
module fxp_align_round
   import fxp_requant_pkg::*;
#(
   parameter int IN_W     = 16,
   parameter int IN_FRAC  = 8,
   parameter int OUT_FRAC = 4,
   parameter bit SIGNED   = 1'b1,
   parameter int WIDE     = 20
) (
   input  logic [IN_W-1:0]        in_data,
   input  rq_mode_e               mode,
   output logic signed [WIDE-1:0] value
);
   localparam int DROP = (IN_FRAC > OUT_FRAC) ? IN_FRAC - OUT_FRAC : 0;
   localparam int PAD  = (OUT_FRAC > IN_FRAC) ? OUT_FRAC - IN_FRAC : 0;

   logic signed [WIDE-1:0] ext;

   generate
      if (SIGNED) begin : g_sext
         assign ext = WIDE'($signed(in_data));
      end else begin : g_zext
         assign ext = WIDE'($unsigned(in_data));
      end

      if (DROP > 0) begin : g_round
         localparam logic [DROP-1:0] LOW_MASK = {DROP{1'b1}} >> 1;
         logic [DROP-1:0]        lost;
         logic signed [WIDE-1:0] kept;
         logic                   guard_bit;
         logic                   sticky_bit;
         logic                   inc;

         assign lost       = in_data[DROP-1:0];
         assign kept       = ext >>> DROP;
         assign guard_bit  = lost[DROP-1];
         assign sticky_bit = |(lost & LOW_MASK);

         always_comb begin
            unique case (mode)
               RQ_FLOOR:     inc = 1'b0;
               RQ_CEIL:      inc = guard_bit | sticky_bit;
               RQ_HALF_UP:   inc = guard_bit;
               RQ_HALF_EVEN: inc = guard_bit & (sticky_bit | kept[0]);
               default:      inc = 1'b0;
            endcase
         end

         assign value = kept + WIDE'(inc);
      end else begin : g_widen
         logic unused_mode;
         assign unused_mode = ^mode;
         assign value = ext <<< PAD;
      end
   endgenerate

endmodule

// File: rtl/fxp_saturate.sv
// Clamps the wide aligned value into the output code range.
module fxp_saturate #(
   parameter int WIDE   = 20,
   parameter int OUT_W  = 10,
   parameter bit SIGNED = 1'b1
) (
   input  logic signed [WIDE-1:0] value,
   output logic [OUT_W-1:0]       code,
   output logic                   ovf
);
   localparam longint HI_L = SIGNED ? (longint'(1) << (OUT_W - 1)) - 1
                                    : (longint'(1) << OUT_W) - 1;
   localparam longint LO_L = SIGNED ? -(longint'(1) << (OUT_W - 1)) : 0;
   localparam logic signed [WIDE-1:0] HI = WIDE'(HI_L);
   localparam logic signed [WIDE-1:0] LO = WIDE'(LO_L);

   always_comb begin
      if (value > HI) begin
         code = HI[OUT_W-1:0];
         ovf  = 1'b1;
      end else if (value < LO) begin
         code = LO[OUT_W-1:0];
         ovf  = 1'b1;
      end else begin
         code = value[OUT_W-1:0];
         ovf  = 1'b0;
      end
   end

endmodule

// File: rtl/fxp_requant.sv
module fxp_requant
   import fxp_requant_pkg::*;
#(
   parameter int IN_W       = 16,
   parameter int IN_FRAC    = 8,
   parameter int OUT_W      = 10,
   parameter int OUT_FRAC   = 4,
   parameter bit SIGNED     = 1'b1,
   parameter bit REGISTERED = 1'b1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              in_valid,
   input  logic [IN_W-1:0]   in_data,
   input  logic [1:0]        mode,
   output logic              out_valid,
   output logic [OUT_W-1:0]  out_data,
   output logic              out_ovf
);
   localparam int PAD  = (OUT_FRAC > IN_FRAC) ? OUT_FRAC - IN_FRAC : 0;
   localparam int WIDE = rq_max(IN_W + PAD + 2, OUT_W + 2);

   generate
      if (OUT_W < 2 || IN_W < 2) begin : g_bad_width
         $error("fxp_requant: widths must be at least 2");
      end
      if (IN_FRAC < 0 || OUT_FRAC < 0 || IN_FRAC > IN_W || OUT_FRAC > OUT_W) begin : g_bad_frac
         $error("fxp_requant: fraction count outside 0..width");
      end
      if (WIDE > 64) begin : g_bad_wide
         $error("fxp_requant: internal width above 64 bits");
      end
   endgenerate

   rq_mode_e               mode_q;
   logic signed [WIDE-1:0] aligned;
   logic [OUT_W-1:0]       sat_code;
   logic                   sat_ovf;

   assign mode_q = rq_mode_e'(mode);

   fxp_align_round #(
      .IN_W(IN_W), .IN_FRAC(IN_FRAC), .OUT_FRAC(OUT_FRAC),
      .SIGNED(SIGNED), .WIDE(WIDE)
   ) u_align (
      .in_data(in_data),
      .mode(mode_q),
      .value(aligned)
   );

   fxp_saturate #(
      .WIDE(WIDE), .OUT_W(OUT_W), .SIGNED(SIGNED)
   ) u_sat (
      .value(aligned),
      .code(sat_code),
      .ovf(sat_ovf)
   );

   generate
      if (REGISTERED) begin : g_reg
         always_ff @(posedge clk) begin
            if (rst) begin
               out_valid <= 1'b0;
               out_data  <= '0;
               out_ovf   <= 1'b0;
            end else begin
               out_valid <= in_valid;
               if (in_valid) begin
                  out_data <= sat_code;
                  out_ovf  <= sat_ovf;
               end
            end
         end
      end else begin : g_comb
         logic unused_ctl;
         assign unused_ctl = clk ^ rst;
         assign out_valid  = in_valid;
         assign out_data   = sat_code;
         assign out_ovf    = sat_ovf;
      end
   endgenerate

endmodule

// File: rtl/fxp_requant_chk.sv
module fxp_requant_chk #(
   parameter int IN_W       = 16,
   parameter int IN_FRAC    = 8,
   parameter int OUT_W      = 10,
   parameter int OUT_FRAC   = 4,
   parameter bit SIGNED     = 1'b1,
   parameter bit REGISTERED = 1'b1
) (
   input logic             clk,
   input logic             rst,
   input logic             in_valid,
   input logic [IN_W-1:0]  in_data,
   input logic [1:0]       mode,
   input logic             out_valid,
   input logic [OUT_W-1:0] out_data,
   input logic             out_ovf
);
   localparam int DROP = (IN_FRAC > OUT_FRAC) ? IN_FRAC - OUT_FRAC : 0;
   localparam logic [OUT_W-1:0] HI_CODE = SIGNED ? {1'b0, {(OUT_W-1){1'b1}}} : {OUT_W{1'b1}};
   localparam logic [OUT_W-1:0] LO_CODE = SIGNED ? {1'b1, {(OUT_W-1){1'b0}}} : {OUT_W{1'b0}};

   generate
      if (REGISTERED) begin : g_reg_props
         p_reset_r1: assert property (@(posedge clk)
            rst |=> (!out_valid && out_data == '0 && !out_ovf));

         p_valid_on_r2: assert property (@(posedge clk) disable iff (rst)
            in_valid |=> out_valid);

         p_valid_off_r2: assert property (@(posedge clk) disable iff (rst)
            !in_valid |=> !out_valid);

         p_hold_r8: assert property (@(posedge clk) disable iff (rst)
            !in_valid |=> ($stable(out_data) && $stable(out_ovf)));

         p_no_overflow_r3: assert property (@(posedge clk) disable iff (rst)
            (out_valid && out_ovf) |-> (out_data == HI_CODE || out_data == LO_CODE));

         if (DROP > 0 && OUT_W + DROP <= IN_W) begin : g_exact
            p_exact_r4: assert property (@(posedge clk) disable iff (rst)
               (in_valid && in_data[DROP-1:0] == '0) |=>
                  (out_ovf || out_data == $past(in_data[DROP +: OUT_W])));
         end
      end
   endgenerate

   always_comb begin
      if (!rst && out_valid) begin
         p_mode_known_r4: assert (!$isunknown(out_data));
      end
   end

endmodule

bind fxp_requant fxp_requant_chk #(
   .IN_W(IN_W), .IN_FRAC(IN_FRAC), .OUT_W(OUT_W), .OUT_FRAC(OUT_FRAC),
   .SIGNED(SIGNED), .REGISTERED(REGISTERED)
) u_chk (
   .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data), .mode(mode),
   .out_valid(out_valid), .out_data(out_data), .out_ovf(out_ovf)
);

// File: tb/fxp_requant_tb_top.sv
module fxp_requant_tb_top;
   localparam int CLK_PERIOD = 10;

   typedef struct {
      logic [9:0] data;
      logic       ovf;
      string      req;
   } exp_t;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        in_valid = 1'b0;
   logic [15:0] in_data = '0;
   logic [1:0]  mode = 2'b00;
   logic        out_valid;
   logic [9:0]  out_data;
   logic        out_ovf;

   logic [7:0]  w_in = '0;
   logic [1:0]  w_mode = 2'b00;
   logic        w_valid;
   logic [11:0] w_data;
   logic        w_ovf;

   int   n_checks = 0;
   int   n_fail = 0;
   int   n_pushed = 0;
   int   n_popped = 0;
   bit   finished = 1'b0;
   exp_t sb[$];
   exp_t last_exp;
   bit   have_last = 1'b0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   fxp_requant #(
      .IN_W(16), .IN_FRAC(8), .OUT_W(10), .OUT_FRAC(4),
      .SIGNED(1'b1), .REGISTERED(1'b1)
   ) dut_i (
      .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data), .mode(mode),
      .out_valid(out_valid), .out_data(out_data), .out_ovf(out_ovf)
   );

   // Widening, combinational variant: Q4.4 in, Q6.6 out.
   fxp_requant #(
      .IN_W(8), .IN_FRAC(4), .OUT_W(12), .OUT_FRAC(6),
      .SIGNED(1'b1), .REGISTERED(1'b0)
   ) dut_w_i (
      .clk(clk), .rst(rst), .in_valid(1'b1), .in_data(w_in), .mode(w_mode),
      .out_valid(w_valid), .out_data(w_data), .out_ovf(w_ovf)
   );

   // Reference: Q8.8 value v (units of 1/256) to Q6.4 code, 4 bits dropped.
   function automatic exp_t model(input int v, input logic [1:0] m);
      exp_t e;
      int q;
      int fr;
      q  = v >>> 4;
      fr = v & 15;
      case (m)
         2'b00: e.req = "R4";
         2'b01: begin e.req = "R5"; if (fr != 0) q++; end
         2'b10: begin e.req = "R6"; if (fr >= 8) q++; end
         default: begin
            e.req = "R7";
            if (fr > 8 || (fr == 8 && (q & 1) != 0)) q++;
         end
      endcase
      e.ovf = 1'b0;
      if (q > 511) begin q = 511; e.ovf = 1'b1; e.req = "R3"; end
      if (q < -512) begin q = -512; e.ovf = 1'b1; e.req = "R3"; end
      e.data = q[9:0];
      return e;
   endfunction

   task automatic drive(input int v, input logic [1:0] m);
      @(negedge clk);
      in_valid = 1'b1;
      in_data  = v[15:0];
      mode     = m;
      sb.push_back(model(v, m));
      n_pushed++;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         in_valid = 1'b0;
         in_data  = 16'hA5A5;
         mode     = 2'b11;
      end
   endtask

   // Scoreboard monitor, samples at the falling edge.
   always @(negedge clk) begin
      if (!rst && !finished) begin
         if (out_valid) begin
            n_checks++;
            if (sb.size() == 0) begin
               n_fail++;
               $display("FAIL R2: result data=%h with nothing expected", out_data);
            end else begin
               last_exp = sb.pop_front();
               have_last = 1'b1;
               n_popped++;
               if (out_data !== last_exp.data || out_ovf !== last_exp.ovf) begin
                  n_fail++;
                  $display("FAIL %s: data=%h ovf=%b expected data=%h ovf=%b",
                           last_exp.req, out_data, out_ovf, last_exp.data, last_exp.ovf);
               end
            end
         end else if (have_last) begin
            n_checks++;
            if (out_data !== last_exp.data || out_ovf !== last_exp.ovf) begin
               n_fail++;
               $display("FAIL R8: idle data=%h ovf=%b expected data=%h ovf=%b",
                        out_data, out_ovf, last_exp.data, last_exp.ovf);
            end
         end
      end
   end

   task automatic check_wide(input logic [7:0] x, input logic [1:0] m);
      logic [11:0] exp_w;
      w_in   = x;
      w_mode = m;
      #1;
      exp_w = {{2{x[7]}}, x, 2'b00};
      n_checks++;
      if (w_data !== exp_w || w_ovf !== 1'b0) begin
         n_fail++;
         $display("FAIL R9: data=%h ovf=%b expected data=%h ovf=0", w_data, w_ovf, exp_w);
      end
   endtask

   task automatic finish_run();
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      n_fail++;
      $display("FAIL watchdog: run did not complete, expected completion");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset state
      n_checks++;
      if (out_valid !== 1'b0 || out_data !== '0 || out_ovf !== 1'b0) begin
         n_fail++;
         $display("FAIL R1: valid=%b data=%h ovf=%b expected 0 0 0", out_valid, out_data, out_ovf);
      end
      rst = 1'b0;

      // R4-R7: ties with even and odd kept LSB, positive and negative, all modes
      for (int m = 0; m < 4; m++) begin
         drive(296, m[1:0]);    // 18.5  -> tie, even kept
         drive(312, m[1:0]);    // 19.5  -> tie, odd kept
         drive(-296, m[1:0]);   // -18.5 -> tie, odd kept (-19)
         drive(300, m[1:0]);    // above half
         drive(289, m[1:0]);    // sticky only
         drive(320, m[1:0]);    // exact, R4 in every mode
      end
      idle(3);
      // R3: clamp at both ends, and rounding carry past the top
      for (int m = 0; m < 4; m++) begin
         drive(32767, m[1:0]);
         drive(-32768, m[1:0]);
         drive(8184, m[1:0]);
         drive(-8192, m[1:0]);
      end
      idle(2);
      // Mixed patterns
      for (int i = 0; i < 200; i++) begin
         int v;
         v = $signed(16'($urandom));
         if (i % 3 == 0) v = v >>> 5;
         drive(v, 2'($urandom));
         if (i % 17 == 0) idle(2);
      end
      idle(4);
      // R2: one result per accepted input
      n_checks++;
      if (n_pushed != n_popped || sb.size() != 0) begin
         n_fail++;
         $display("FAIL R2: results=%0d expected=%0d", n_popped, n_pushed);
      end
      // R9: widening path ignores mode
      for (int m = 0; m < 4; m++) begin
         check_wide(8'h9B, m[1:0]);
         check_wide(8'h7F, m[1:0]);
         check_wide(8'h35, m[1:0]);
      end
      finish_run();
   end

endmodule